// File: doc/BRIEF.md
# Miss-Parallelism Cost Accumulator

This block is a table of outstanding cache misses in which each entry measures how much processor stall its miss has caused. In every clock cycle the stall of that cycle is split evenly among the demand misses being tracked. A miss that waits alone therefore collects one full cycle of cost per cycle. Misses that overlap collect fractions of a cycle. Prefetch misses are tracked but neither collect cost nor share in the split.

A new miss arrives on the allocate port with its line address and a demand flag. The completion of a miss arrives on the fill port with its line address. One cycle after a fill, the block reports the line address and its cost, reduced to a 3-bit level, for use by a cost-aware replacement policy. A request for a line that is already tracked merges into the existing entry. A request for a new line while the table is full is refused with a stall signal.

Top module: `mshr_cost_top`

## Requirements
- R1: After reset no entry is held, `retireValid` is 0, and `allocStall` is 0 while no allocate is presented.
- R2: A demand miss that is the only demand entry gains exactly one cycle of cost per clock edge. A miss allocated at one edge and filled k edges later reports a cost of k cycles.
- R3: A prefetch entry (allocated with `allocDemand`=0) keeps a cost of 0, is not counted in the sharing count, and retires with `retireCost`=0.
- R4: At each edge, every held demand entry adds floor(1024/N)/1024 cycles, where N is the number of demand entries held before that edge. N includes an entry that is filled at that edge, and that entry still receives the increment. An entry allocated at an edge starts from 0 and first adds at the following edge.
- R5: An allocate whose address matches a held entry creates no new entry and leaves its cost unchanged. If `allocDemand` is 1 it turns the entry into a demand entry, which takes part from the next edge on. Two held entries never share an address.
- R6: An allocate for an address that is not held, while all 32 entries are held, drives `allocStall` to 1 in the same cycle and is dropped. An allocate that merges never stalls.
- R7: A fill whose address is held frees that entry. In the following cycle it raises `retireValid` for one cycle, with `retireAddr` equal to the fill address. A fill whose address is not held has no effect and produces no retirement.
- R8: `retireCost` equals min(floor(C/60), 7), where C is the integer part, in cycles, of the entry's cost including the increment of the fill edge. Any cost of 420 cycles or more gives 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate request for a new miss |
| allocAddr | input | 32 | Line address of the new miss |
| allocDemand | input | 1 | 1 = demand miss, 0 = prefetch |
| allocStall | output | 1 | Allocate refused, table full (combinational) |
| fillValid | input | 1 | A miss has completed |
| fillAddr | input | 32 | Line address of the completed miss |
| retireValid | output | 1 | Retirement report valid (one cycle after fill) |
| retireAddr | output | 32 | Line address of the retired miss |
| retireCost | output | 3 | Quantized stall cost of the retired miss |

## Verification
The assertions assume that an allocate and a fill never present the same line address in the same cycle. They also assume that costs stay well below the 4095-cycle saturation point, so that each isolated-miss increment is visible as a full cycle. The stimulus keeps to both assumptions. The random generator clears the fill request whenever it would coincide with the allocated address. Filled lines come from a small address pool, so no entry stays resident for thousands of cycles. The reference model computes the expected costs with the same floor(1024/N) step that R4 states, so quantization boundaries compare exactly.

// File: rtl/mshr_cost_pkg.sv
package mshr_cost_pkg;
  parameter int MSHR_ENTRIES = 32;
  parameter int LINE_ADDR_W  = 32;
  parameter int COST_FRAC_W  = 10;
  parameter int COST_INT_W   = 12;
  parameter int QCOST_W      = 3;

  localparam int IDX_W   = $clog2(MSHR_ENTRIES);
  localparam int CNT_W   = $clog2(MSHR_ENTRIES + 1);
  localparam int STEP_W  = COST_FRAC_W + 1;
  localparam int COST_W  = COST_INT_W + COST_FRAC_W;
  localparam int ONE_FIX = 1 << COST_FRAC_W;

  typedef struct packed {
    logic              allocEn;
    logic [IDX_W-1:0]  allocIdx;
    logic              mergeEn;
    logic [IDX_W-1:0]  mergeIdx;
    logic              mergeDemand;
    logic              fillEn;
    logic [IDX_W-1:0]  fillIdx;
    logic [STEP_W-1:0] step;
  } strobe_t;
endpackage

// File: rtl/mshr_cost_quant.sv
module mshr_cost_quant
  import mshr_cost_pkg::*;
#(
  parameter int BUCKET = 60
) (
  input  logic [COST_W-1:0]  costIn,
  output logic [QCOST_W-1:0] level
);
  localparam int LEVELS = 1 << QCOST_W;

  logic [COST_INT_W-1:0] wholeCycles;
  logic [LEVELS-2:0]     overEdge;

  assign wholeCycles = costIn[COST_W-1:COST_FRAC_W];

  // one comparator per bucket boundary; the level is the number crossed
  for (genvar k = 1; k < LEVELS; k++) begin : g_edge
    assign overEdge[k-1] = (wholeCycles >= COST_INT_W'(k * BUCKET));
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < LEVELS - 1; k++) begin
      level = level + QCOST_W'(overEdge[k]);
    end
  end
endmodule

// File: rtl/mshr_cost_ctrl.sv
module mshr_cost_ctrl
  import mshr_cost_pkg::*;
(
  input  logic                                      allocValid,
  input  logic [LINE_ADDR_W-1:0]                    allocAddr,
  input  logic                                      allocDemand,
  input  logic                                      fillValid,
  input  logic [LINE_ADDR_W-1:0]                    fillAddr,
  input  logic [MSHR_ENTRIES-1:0]                   entryValid,
  input  logic [MSHR_ENTRIES-1:0]                   entryDemand,
  input  logic [MSHR_ENTRIES-1:0][LINE_ADDR_W-1:0]  entryAddr,
  output logic                                      allocStall,
  output strobe_t                                   strobes
);
  // reciprocal table, entry n holds floor(ONE_FIX / n)
  logic [STEP_W-1:0] recipTab [MSHR_ENTRIES+1];
  assign recipTab[0] = '0;
  for (genvar n = 1; n <= MSHR_ENTRIES; n++) begin : g_recip
    assign recipTab[n] = STEP_W'(ONE_FIX / n);
  end

  logic             allocHit, fillHit, freeFound;
  logic [IDX_W-1:0] allocHitIdx, fillHitIdx, freeIdx;
  logic [CNT_W-1:0] demandCount;
  logic             tableFull;

  always_comb begin
    allocHit    = 1'b0;
    allocHitIdx = '0;
    fillHit     = 1'b0;
    fillHitIdx  = '0;
    freeFound   = 1'b0;
    freeIdx     = '0;
    demandCount = '0;
    for (int i = 0; i < MSHR_ENTRIES; i++) begin
      if (entryValid[i] && entryAddr[i] == allocAddr && !allocHit) begin
        allocHit    = 1'b1;
        allocHitIdx = IDX_W'(i);
      end
      if (entryValid[i] && entryAddr[i] == fillAddr && !fillHit) begin
        fillHit    = 1'b1;
        fillHitIdx = IDX_W'(i);
      end
      if (!entryValid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
      if (entryValid[i] && entryDemand[i]) begin
        demandCount = demandCount + CNT_W'(1);
      end
    end
  end

  assign tableFull = &entryValid;

  always_comb begin
    strobes             = '0;
    strobes.allocEn     = allocValid && !allocHit && !tableFull;
    strobes.allocIdx    = freeIdx;
    strobes.mergeEn     = allocValid && allocHit;
    strobes.mergeIdx    = allocHitIdx;
    strobes.mergeDemand = allocDemand;
    strobes.fillEn      = fillValid && fillHit;
    strobes.fillIdx     = fillHitIdx;
    strobes.step        = recipTab[demandCount];
  end

  assign allocStall = allocValid && !allocHit && tableFull;
endmodule

// File: rtl/mshr_cost_datapath.sv
module mshr_cost_datapath
  import mshr_cost_pkg::*;
#(
  parameter int BUCKET = 60
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  strobe_t                                   strobes,
  input  logic [LINE_ADDR_W-1:0]                    allocAddr,
  input  logic                                      allocDemand,
  output logic [MSHR_ENTRIES-1:0]                   entryValid,
  output logic [MSHR_ENTRIES-1:0]                   entryDemand,
  output logic [MSHR_ENTRIES-1:0][LINE_ADDR_W-1:0]  entryAddr,
  output logic [MSHR_ENTRIES-1:0][COST_W-1:0]       entryCost,
  output logic                                      retireValid,
  output logic [LINE_ADDR_W-1:0]                    retireAddr,
  output logic [QCOST_W-1:0]                        retireCost
);
  localparam logic [COST_W-1:0] COST_MAX = '1;

  logic [MSHR_ENTRIES-1:0][COST_W-1:0] costNext;
  logic [COST_W:0]                     costSum [MSHR_ENTRIES];
  logic [QCOST_W-1:0]                  fillLevel;

  // saturating per-entry increment; prefetch entries hold their cost
  always_comb begin
    for (int i = 0; i < MSHR_ENTRIES; i++) begin
      costSum[i] = {1'b0, entryCost[i]} + (COST_W+1)'(strobes.step);
      if (!(entryValid[i] && entryDemand[i])) begin
        costNext[i] = entryCost[i];
      end else if (costSum[i][COST_W]) begin
        costNext[i] = COST_MAX;
      end else begin
        costNext[i] = costSum[i][COST_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entryValid  <= '0;
      entryDemand <= '0;
      entryAddr   <= '0;
      entryCost   <= '0;
    end else begin
      for (int i = 0; i < MSHR_ENTRIES; i++) begin
        if (strobes.fillEn && strobes.fillIdx == IDX_W'(i)) begin
          entryValid[i] <= 1'b0;
        end else if (strobes.allocEn && strobes.allocIdx == IDX_W'(i)) begin
          entryValid[i]  <= 1'b1;
          entryDemand[i] <= allocDemand;
          entryAddr[i]   <= allocAddr;
          entryCost[i]   <= '0;
        end else begin
          entryCost[i] <= costNext[i];
          if (strobes.mergeEn && strobes.mergeIdx == IDX_W'(i) && strobes.mergeDemand) begin
            entryDemand[i] <= 1'b1;
          end
        end
      end
    end
  end

  mshr_cost_quant #(.BUCKET(BUCKET)) quant_i (
    .costIn (costNext[strobes.fillIdx]),
    .level  (fillLevel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retireValid <= 1'b0;
      retireAddr  <= '0;
      retireCost  <= '0;
    end else begin
      retireValid <= strobes.fillEn;
      if (strobes.fillEn) begin
        retireAddr <= entryAddr[strobes.fillIdx];
        retireCost <= fillLevel;
      end
    end
  end
endmodule

// File: rtl/mshr_cost_top.sv
module mshr_cost_top
  import mshr_cost_pkg::*;
#(
  parameter int QUANT_BUCKET = 60
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   allocValid,
  input  logic [LINE_ADDR_W-1:0] allocAddr,
  input  logic                   allocDemand,
  output logic                   allocStall,
  input  logic                   fillValid,
  input  logic [LINE_ADDR_W-1:0] fillAddr,
  output logic                   retireValid,
  output logic [LINE_ADDR_W-1:0] retireAddr,
  output logic [QCOST_W-1:0]     retireCost
);
  strobe_t                                  strobes;
  logic [MSHR_ENTRIES-1:0]                  entryValid;
  logic [MSHR_ENTRIES-1:0]                  entryDemand;
  logic [MSHR_ENTRIES-1:0][LINE_ADDR_W-1:0] entryAddr;
  logic [MSHR_ENTRIES-1:0][COST_W-1:0]      entryCost;

  mshr_cost_ctrl ctrl_i (
    .allocValid  (allocValid),
    .allocAddr   (allocAddr),
    .allocDemand (allocDemand),
    .fillValid   (fillValid),
    .fillAddr    (fillAddr),
    .entryValid  (entryValid),
    .entryDemand (entryDemand),
    .entryAddr   (entryAddr),
    .allocStall  (allocStall),
    .strobes     (strobes)
  );

  mshr_cost_datapath #(.BUCKET(QUANT_BUCKET)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .allocAddr   (allocAddr),
    .allocDemand (allocDemand),
    .entryValid  (entryValid),
    .entryDemand (entryDemand),
    .entryAddr   (entryAddr),
    .entryCost   (entryCost),
    .retireValid (retireValid),
    .retireAddr  (retireAddr),
    .retireCost  (retireCost)
  );
endmodule

// File: rtl/mshr_cost_checker.sv
module mshr_cost_checker
  import mshr_cost_pkg::*;
(
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      allocStall,
  input logic                                      fillValid,
  input logic                                      retireValid,
  input logic [LINE_ADDR_W-1:0]                    retireAddr,
  input logic [MSHR_ENTRIES-1:0]                   entryValid,
  input logic [MSHR_ENTRIES-1:0]                   entryDemand,
  input logic [MSHR_ENTRIES-1:0][LINE_ADDR_W-1:0]  entryAddr,
  input logic [MSHR_ENTRIES-1:0][COST_W-1:0]       entryCost
);
  localparam logic [COST_W-1:0] ONE_STEP  = COST_W'(ONE_FIX);
  localparam logic [COST_W-1:0] SAFE_CAP  = COST_W'((1 << COST_W) - 2 * ONE_FIX);

  logic retireHeld, dupFound;
  int   demandLive;

  always_comb begin
    retireHeld = 1'b0;
    dupFound   = 1'b0;
    demandLive = $countones(entryValid & entryDemand);
    for (int i = 0; i < MSHR_ENTRIES; i++) begin
      if (entryValid[i] && entryAddr[i] == retireAddr) retireHeld = 1'b1;
      for (int j = i + 1; j < MSHR_ENTRIES; j++) begin
        if (entryValid[i] && entryValid[j] && entryAddr[i] == entryAddr[j]) dupFound = 1'b1;
      end
    end
  end

  p_stall_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    allocStall |-> (&entryValid));

  p_retire_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retireValid |-> !retireHeld);

  p_retire_follows_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retireValid |-> $past(fillValid));

  p_unique_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dupFound);

  for (genvar i = 0; i < MSHR_ENTRIES; i++) begin : g_entry
    p_prefetch_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (entryValid[i] && !entryDemand[i]) |=>
        (!entryValid[i] || entryDemand[i] || $stable(entryCost[i])));

    p_isolated_full_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (demandLive == 1 && entryValid[i] && entryDemand[i] && entryCost[i] < SAFE_CAP) |=>
        (!entryValid[i] || entryCost[i] == $past(entryCost[i]) + ONE_STEP));

    p_fresh_entry_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(entryValid[i]) |-> (entryCost[i] == '0));
  end
endmodule

bind mshr_cost_top mshr_cost_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .allocStall  (allocStall),
  .fillValid   (fillValid),
  .retireValid (retireValid),
  .retireAddr  (retireAddr),
  .entryValid  (entryValid),
  .entryDemand (entryDemand),
  .entryAddr   (entryAddr),
  .entryCost   (entryCost)
);

// File: tb/mshr_cost_top_tb_top.sv
`timescale 1ns/1ps
module mshr_cost_top_tb_top;
  import mshr_cost_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n = 1'b0;
  logic                   allocValid = 1'b0;
  logic [LINE_ADDR_W-1:0] allocAddr = '0;
  logic                   allocDemand = 1'b0;
  logic                   allocStall;
  logic                   fillValid = 1'b0;
  logic [LINE_ADDR_W-1:0] fillAddr = '0;
  logic                   retireValid;
  logic [LINE_ADDR_W-1:0] retireAddr;
  logic [QCOST_W-1:0]     retireCost;

  mshr_cost_top dut_i (.*);

  int checks = 0;
  int fails  = 0;
  string phaseReq = "R2";

  bit                   mValid [MSHR_ENTRIES];
  bit                   mDem   [MSHR_ENTRIES];
  logic [LINE_ADDR_W-1:0] mAddr [MSHR_ENTRIES];
  longint               mCost  [MSHR_ENTRIES];

  function automatic longint expLevel(longint c);
    longint w = (c >> COST_FRAC_W) / 60;
    return (w > 7) ? 7 : w;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // drives one cycle from a falling edge and checks it at the next falling edge
  task automatic cyc(bit aV, logic [LINE_ADDR_W-1:0] aA, bit aD, bit fV, logic [LINE_ADDR_W-1:0] fA);
    int hit = -1, fhit = -1, freeI = -1, n = 0;
    bit full = 1'b1, expStall, expRet = 1'b0, retDem = 1'b0;
    longint stepV = 0, retQ = 0;
    allocValid = aV; allocAddr = aA; allocDemand = aD;
    fillValid = fV; fillAddr = fA;
    #1;
    for (int i = 0; i < MSHR_ENTRIES; i++) begin
      if (mValid[i] && aV && mAddr[i] == aA && hit < 0) hit = i;
      if (mValid[i] && fV && mAddr[i] == fA && fhit < 0) fhit = i;
      if (!mValid[i]) begin full = 1'b0; if (freeI < 0) freeI = i; end
      if (mValid[i] && mDem[i]) n++;
    end
    expStall = aV && hit < 0 && full;
    check(allocStall == expStall, "R6", "allocStall", allocStall, expStall);
    if (n > 0) stepV = ONE_FIX / n;
    for (int i = 0; i < MSHR_ENTRIES; i++)
      if (mValid[i] && mDem[i]) mCost[i] += stepV;
    if (fhit >= 0) begin
      expRet = 1'b1; retQ = expLevel(mCost[fhit]); retDem = mDem[fhit];
      mValid[fhit] = 1'b0;
    end
    if (aV) begin
      if (hit >= 0) mDem[hit] = mDem[hit] | aD;
      else if (!full) begin
        mValid[freeI] = 1'b1; mDem[freeI] = aD; mAddr[freeI] = aA; mCost[freeI] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    allocValid = 1'b0; fillValid = 1'b0;
    check(retireValid == expRet, "R7", "retireValid", retireValid, expRet);
    if (expRet) begin
      check(retireAddr == fA, "R7", "retireAddr", retireAddr, fA);
      check(retireCost == retQ, retDem ? phaseReq : "R3", "retireCost", retireCost, retQ);
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, '0, 0, 0, '0);
  endtask

  task automatic lone(logic [LINE_ADDR_W-1:0] a, int k);
    cyc(1, a, 1, 0, '0);
    idle(k - 1);
    cyc(0, '0, 0, 1, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "cycles", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MSHR_ENTRIES; i++) begin
      mValid[i] = 0; mDem[i] = 0; mAddr[i] = '0; mCost[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(retireValid == 1'b0, "R1", "retireValid after reset", retireValid, 0);
    check(allocStall == 1'b0, "R1", "allocStall after reset", allocStall, 0);

    // R2 and R8: lone demand misses at bucket edges and saturation
    phaseReq = "R2"; lone(32'h100, 7); lone(32'h104, 59);
    phaseReq = "R8"; lone(32'h108, 60); lone(32'h10C, 419); lone(32'h110, 420); lone(32'h114, 500);

    // R3: prefetch beside one demand miss
    phaseReq = "R3";
    cyc(1, 32'h200, 0, 0, '0);
    cyc(1, 32'h204, 1, 0, '0);
    idle(130);
    cyc(0, '0, 0, 1, 32'h204);
    cyc(0, '0, 0, 1, 32'h200);

    // R4: overlapping demand misses share the stall
    phaseReq = "R4";
    cyc(1, 32'h300, 1, 0, '0);
    cyc(1, 32'h304, 1, 0, '0);
    cyc(1, 32'h308, 1, 0, '0);
    idle(200);
    cyc(0, '0, 0, 1, 32'h300);
    idle(100);
    cyc(0, '0, 0, 1, 32'h304);
    cyc(0, '0, 0, 1, 32'h308);

    // R5: merge and promotion
    phaseReq = "R5";
    cyc(1, 32'h400, 0, 0, '0);
    idle(10);
    cyc(1, 32'h400, 1, 0, '0);
    idle(90);
    cyc(0, '0, 0, 1, 32'h400);
    cyc(0, '0, 0, 1, 32'h400);

    // R7: fill of an address never held
    cyc(0, '0, 0, 1, 32'h4444);

    // R6: full table
    phaseReq = "R6";
    for (int i = 0; i < MSHR_ENTRIES; i++) cyc(1, 32'h1000 + i, 1, 0, '0);
    cyc(1, 32'h9999, 1, 0, '0);
    cyc(1, 32'h1005, 0, 0, '0);
    cyc(0, '0, 0, 1, 32'h1003);
    cyc(1, 32'h9999, 1, 0, '0);
    for (int i = 0; i < MSHR_ENTRIES; i++) cyc(0, '0, 0, 1, 32'h1000 + i);
    cyc(0, '0, 0, 1, 32'h9999);

    // R4: random overlapping traffic
    phaseReq = "R4";
    for (int c = 0; c < 4000; c++) begin
      bit aV = ($urandom % 3) == 0;
      bit fV = ($urandom % 3) == 0;
      logic [LINE_ADDR_W-1:0] aA = 32'h2000 + ($urandom % 40);
      logic [LINE_ADDR_W-1:0] fA = 32'h2000 + ($urandom % 40);
      bit aD = ($urandom % 4) != 0;
      if (aV && fV && aA == fA) fV = 1'b0;
      cyc(aV, aA, aD, fV, fA);
    end
    for (int i = 0; i < 40; i++) cyc(0, '0, 0, 1, 32'h2000 + i);

    summary();
    $finish;
  end
endmodule